// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block connects a clocked request/acknowledge port to an external asynchronous static RAM of 64K words of 16 bits. The host presents a word address, write data, a two-bit byte-lane mask and a read/write select together with a one-cycle request. The sequencer then drives the memory's active-low strobes and its data bus for the number of clock cycles that the memory's timing needs. It answers with a one-cycle done strobe, and for reads it returns the captured data on that strobe.

Every phase length comes from nanosecond timing figures held as picosecond parameters. Each figure is divided by the clock period and rounded up, with a floor of one cycle. The data bus leaves the block as a driven value plus a drive enable, ready for a tri-state pad buffer. Output enable stays inactive for the whole of every write. A read is always followed by a recovery gap before the next access, so the controller and the memory never drive the bus together.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, chip select, write enable, output enable and both byte enables are high, the bus drive enable is low and done is low.
- R2: An accepted write holds chip select and write enable low, with output enable high, for WR_CYC cycles starting the cycle after acceptance. WR_CYC is the largest of write pulse, data setup and address-to-end times, rounded up to whole clock periods (2 with the defaults). Address and write data are driven, and the drive enable is high, from the first of these cycles.
- R3: After the write pulse there is one hold cycle. In it write enable is high while chip select, byte enables, address, write data and drive enable are unchanged. In the next cycle all strobes are high, the drive enable is low and done is high for one cycle.
- R4: Mask bit 0 enables bits 7:0 through the low byte enable, and mask bit 1 enables bits 15:8 through the high byte enable. A lane with mask bit 0 is not written. A mask of 00 still pulls chip select low for the full access.
- R5: An accepted read holds chip select and output enable low, with write enable high and the drive enable low, for RD_CYC cycles starting the cycle after acceptance. RD_CYC is the larger of the address access and output-enable access times, rounded up (2 with the defaults).
- R6: The bus is sampled at the last read cycle. In the following cycle all strobes are high and done is high for one cycle, and the read data output holds the sampled word. Any lane whose mask bit is 0 reads as zero.
- R7: A read is followed by REC_CYC cycles with all strobes high before any new request can be accepted. REC_CYC is the bus release time rounded up, at least 1 (1 with the defaults). Write enable never falls unless chip select was high in the cycle before.
- R8: A request, with any address, data, mask or direction, that arrives while an access or its recovery is in progress has no effect on the pins or on the result.
- R9: Output enable is high in every cycle in which write enable is low, and the bus is driven only while chip select is low and output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, sampled when idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Word address |
| wdata | input | 16 | Write data |
| bmask | input | 2 | Byte-lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | 16 | Read data, valid with done after a read |
| mem_addr | output | 16 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | High byte enable, active low |
| mem_lb_n | output | 1 | Low byte enable, active low |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the bus pad buffer |
| mem_dq_i | input | 16 | Data from the bus pad |

## Verification
Some rules hold on every cycle, and the assertions check those continuously. Output enable is never low while write enable is low. The bus is driven only during a selected write. Each write-enable rise is followed by a hold cycle with a stable address. Every write starts from a deselected cycle, and done lasts one cycle. The rest can only be shown by the bench's scenarios against a model of the memory that fills from the pins. These are the exact phase lengths, the mapping of each mask bit to its byte lane, the zeroing of unmasked lanes on reads, and the ignoring of requests that arrive with different fields while the controller is busy.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_HOLD   = 2'd2,
    ST_RECOV  = 2'd3
  } seq_state_t;

  // Whole clock cycles covering a time in picoseconds, never fewer than one.
  function automatic int ps_to_cycles(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_lane_capture.sv
`timescale 1ns/1ps
module sram_lane_capture #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    capture,
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] q
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        q[l*LANE_W +: LANE_W] <= '0;
      end else if (capture) begin
        q[l*LANE_W +: LANE_W] <= lane_en[l] ? din[l*LANE_W +: LANE_W] : '0;
      end
    end
  end
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LANES   = 2,
  parameter int LANE_W  = 8,
  parameter int CNT_W   = 4,
  parameter int WR_CYC  = 2,
  parameter int RD_CYC  = 2,
  parameter int REC_CYC = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        bmask,
  input  logic                    timer_done,
  output logic                    timer_load,
  output logic [CNT_W-1:0]        timer_val,
  output logic                    capture,
  output logic [LANES-1:0]        lanes_sel,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    cs_n,
  output logic                    we_n,
  output logic                    oe_n,
  output logic [LANES-1:0]        be_n,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe,
  output logic                    done
);
  seq_state_t       state;
  logic             op_wr;
  logic [LANES-1:0] op_mask;

  assign lanes_sel = op_mask;

  // Timer loads and the read-sample strobe.
  always_comb begin
    timer_load = 1'b0;
    timer_val  = '0;
    capture    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req) begin
          timer_load = 1'b1;
          timer_val  = wr ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
        end
      end
      ST_ACCESS: begin
        if (timer_done && !op_wr) begin
          capture    = 1'b1;
          timer_load = 1'b1;
          timer_val  = CNT_W'(REC_CYC - 1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_wr    <= 1'b0;
      op_mask  <= '0;
      mem_addr <= '0;
      cs_n     <= 1'b1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      be_n     <= '1;
      dq_o     <= '0;
      dq_oe    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req) begin
            op_wr    <= wr;
            op_mask  <= bmask;
            mem_addr <= addr;
            cs_n     <= 1'b0;
            be_n     <= ~bmask;
            we_n     <= ~wr;
            oe_n     <= wr;
            dq_oe    <= wr;
            if (wr) dq_o <= wdata;
            state    <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          if (timer_done) begin
            if (op_wr) begin
              we_n  <= 1'b1;
              state <= ST_HOLD;
            end else begin
              cs_n  <= 1'b1;
              oe_n  <= 1'b1;
              be_n  <= '1;
              done  <= 1'b1;
              state <= ST_RECOV;
            end
          end
        end
        ST_HOLD: begin
          cs_n  <= 1'b1;
          be_n  <= '1;
          dq_oe <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        ST_RECOV: begin
          if (timer_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LANE_W    = 8,
  parameter int CLK_PS    = 5000,
  parameter int T_WP_PS   = 7000,
  parameter int T_DW_PS   = 5000,
  parameter int T_AW_PS   = 7000,
  parameter int T_AA_PS   = 10000,
  parameter int T_OEA_PS  = 5000,
  parameter int T_REL_PS  = 5000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*LANE_W-1:0]   wdata,
  input  logic [1:0]            bmask,
  output logic                  done,
  output logic [2*LANE_W-1:0]   rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_cs_n,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic                  mem_ub_n,
  output logic                  mem_lb_n,
  output logic [2*LANE_W-1:0]   mem_dq_o,
  output logic                  mem_dq_oe,
  input  logic [2*LANE_W-1:0]   mem_dq_i
);
  localparam int LANES   = 2;
  localparam int WR_CYC  = ps_to_cycles(max3(T_WP_PS, T_DW_PS, T_AW_PS), CLK_PS);
  localparam int RD_CYC  = ps_to_cycles(max3(T_AA_PS, T_OEA_PS, 0), CLK_PS);
  localparam int REC_CYC = ps_to_cycles(T_REL_PS, CLK_PS);
  localparam int MAX_CYC = max3(WR_CYC, RD_CYC, REC_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;

  logic             t_load, t_done, cap;
  logic [CNT_W-1:0] t_val;
  logic [LANES-1:0] lanes, be_n;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_done)
  );

  sram_seq_fsm #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .CNT_W(CNT_W),
    .WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .REC_CYC(REC_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .bmask(bmask), .timer_done(t_done), .timer_load(t_load), .timer_val(t_val),
    .capture(cap), .lanes_sel(lanes), .mem_addr(mem_addr), .cs_n(mem_cs_n),
    .we_n(mem_we_n), .oe_n(mem_oe_n), .be_n(be_n), .dq_o(mem_dq_o),
    .dq_oe(mem_dq_oe), .done(done)
  );

  sram_lane_capture #(.LANES(LANES), .LANE_W(LANE_W)) u_cap (
    .clk(clk), .rst(rst), .capture(cap), .lane_en(lanes), .din(mem_dq_i), .q(rdata)
  );

  assign mem_lb_n = be_n[0];
  assign mem_ub_n = be_n[1];
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
`timescale 1ns/1ps
module sram_seq_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !done));

  a_r9_oe_off_in_write: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  a_r9_drive_only_write: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_cs_n && mem_oe_n));

  a_r3_hold_after_we: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_cs_n && mem_dq_oe && $stable(mem_addr)));

  a_r7_gap_before_write: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(mem_cs_n));

  a_r8_addr_stable_selected: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr), .done(done)
);

// File: tb/sim_sram_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sram_seq_ctrl;
  // Expected phase lengths from the requirements: ceil(ns / 5 ns).
  localparam int EXP_WR  = (7000 + 4999) / 5000;   // R2: 2
  localparam int EXP_RD  = (10000 + 4999) / 5000;  // R5: 2
  localparam int EXP_REC = (5000 + 4999) / 5000;   // R7: 1

  logic clk = 1'b0, rst = 1'b1;
  logic req = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [1:0]  bmask = '0;
  logic        done;
  logic [15:0] rdata, mem_addr, mem_dq_o, mem_dq_i;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;

  int compared = 0, mismatched = 0;
  bit finished = 1'b0;
  logic [15:0] dev    [0:255];
  logic [15:0] shadow [0:255];

  always #2.5 clk = ~clk;

  sram_seq_ctrl u0 (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .bmask(bmask), .done(done), .rdata(rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Memory device model: filled from the pins, drives A5 noise on idle lanes.
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) dev[i] <= 16'h0000;
    end else if (!mem_cs_n && !mem_we_n) begin
      if (!mem_lb_n) dev[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
      if (!mem_ub_n) dev[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
    end
  end

  always_comb begin
    mem_dq_i = 16'hA5A5;
    if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
      if (!mem_lb_n) mem_dq_i[7:0]  = dev[mem_addr[7:0]][7:0];
      if (!mem_ub_n) mem_dq_i[15:8] = dev[mem_addr[7:0]][15:8];
    end
  end

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", rq, what, act, exp, $time);
    end
  endtask

  // Pin vector {cs,we,oe,ub,lb,dq_oe,done}.
  task automatic chk_pins(input string rq, input logic [6:0] exp);
    chk(rq, "pins{cs,we,oe,ub,lb,oe_dq,done}",
        {25'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, done},
        {25'd0, exp});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_pins("R1", 7'b1111100);
    end
  endtask

  task automatic do_op(input bit w, input logic [7:0] a, input logic [15:0] d,
                       input logic [1:0] m, input bit pester);
    int n_busy;
    logic [15:0] expd;
    logic [6:0]  be;
    be = {1'b0, 1'b0, 1'b0, ~m[1], ~m[0], 1'b0, 1'b0};
    @(negedge clk);
    req = 1'b1; wr = w; addr = {8'h00, a}; wdata = d; bmask = m;
    n_busy = w ? EXP_WR + 1 : EXP_RD + EXP_REC;
    expd = {m[1] ? shadow[a][15:8] : 8'h00, m[0] ? shadow[a][7:0] : 8'h00};
    if (w) begin
      if (m[0]) shadow[a][7:0]  = d[7:0];
      if (m[1]) shadow[a][15:8] = d[15:8];
    end
    for (int i = 1; i <= n_busy + 1; i++) begin
      @(negedge clk);
      if (i == 1) begin
        if (pester) begin
          wr = ~w; addr = {8'h00, ~a}; wdata = ~d; bmask = ~m;  // R8: busy request
        end else req = 1'b0;
      end
      if (i == n_busy + 1) req = 1'b0;
      if (w) begin
        if (i <= EXP_WR) begin
          chk_pins(pester ? "R8" : "R2", 7'b0010010 | be);
          chk("R2", "mem_addr", {16'd0, mem_addr}, {24'd0, a});
          chk("R4", "mem_dq_o", {16'd0, mem_dq_o}, {16'd0, d});
        end else if (i == EXP_WR + 1) begin
          chk_pins("R3", 7'b0110010 | be);
          chk("R3", "mem_addr hold", {16'd0, mem_addr}, {24'd0, a});
          chk("R3", "mem_dq_o hold", {16'd0, mem_dq_o}, {16'd0, d});
        end else begin
          chk_pins("R3", 7'b1111101);
        end
      end else begin
        if (i <= EXP_RD) begin
          chk_pins(pester ? "R8" : "R5", 7'b0100000 | be);
          chk("R5", "mem_addr", {16'd0, mem_addr}, {24'd0, a});
        end else if (i == EXP_RD + 1) begin
          chk_pins("R6", 7'b1111101);
          chk("R6", "rdata", {16'd0, rdata}, {16'd0, expd});
        end else begin
          chk_pins(i == n_busy + 1 ? "R7" : "R7", 7'b1111100);
        end
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 16'h0000;
    repeat (3) @(negedge clk);
    chk_pins("R1", 7'b1111100);           // during reset
    rst = 1'b0;
    idle(2);                               // R1 after release
    do_op(1'b1, 8'd3, 16'h1234, 2'b11, 1'b0);   // R2 R3 word write
    do_op(1'b0, 8'd3, 16'h0000, 2'b11, 1'b0);   // R5 R6 word read
    do_op(1'b1, 8'd3, 16'hABCD, 2'b01, 1'b0);   // R4 low byte write
    do_op(1'b0, 8'd3, 16'h0000, 2'b11, 1'b0);   // R4 expect 12CD
    do_op(1'b1, 8'd5, 16'hBEEF, 2'b10, 1'b0);   // R4 high byte write
    do_op(1'b0, 8'd5, 16'h0000, 2'b01, 1'b0);   // R6 lane zeroing -> 0000
    do_op(1'b0, 8'd5, 16'h0000, 2'b10, 1'b0);   // R6 -> BE00
    do_op(1'b0, 8'd5, 16'h0000, 2'b00, 1'b0);   // R4 selected, no lanes
    idle(1);
    do_op(1'b1, 8'd9, 16'h5A3C, 2'b11, 1'b1);   // R8 write with busy requests
    do_op(1'b0, 8'd9, 16'h0000, 2'b11, 1'b1);   // R8 R7 read with busy requests
    do_op(1'b1, 8'd9, 16'h00FF, 2'b00, 1'b0);   // R4 empty-mask write changes nothing
    do_op(1'b0, 8'd9, 16'h0000, 2'b11, 1'b0);   // R4 expect 5A3C
    idle(2);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule